// File: doc/BRIEF.md
# ADC Core Timing Sequencer

This block produces the digital timing of a single ADC core's conversion. On an accepted start pulse it captures its configuration, then divides the source clock into a core clock. The core clock appears as a one-source-cycle enable, `core_tick`. The block counts core clock periods through a conversion whose length follows the selected resolution. When the count ends it pulses `data_ready`. A programmable number of core periods before that, it pulses `early_irq`, so that software or a DMA engine can be woken up ahead of the data.

Some pairs of resolution and early-interrupt lead cannot be met, because the lead would reach too far back into a short conversion. For such a pair the sequencer raises `cfg_err`, shortens the lead to the longest one that is allowed, and still completes the conversion.

Control is a two-state machine:
- `ST_IDLE` moves to `ST_CONV` on the transition "accept", which is `start` sampled high while idle.
- `ST_CONV` returns to `ST_IDLE` on the transition "finish", which is the core tick that ends the final core period.
- No other transitions exist. In `ST_CONV` a `start` pulse has no effect.

Top module: `adc_core_sequencer`

## Requirements
- R1: After reset, `busy`, `core_tick`, `early_irq`, `data_ready` and `cfg_err` are all 0.
- R2: With divider code D, one core period lasts 2·D source cycles for D from 1 to 127. D = 0 behaves like D = 1. After the accepting edge, `core_tick` is high in the last source cycle of each core period. `core_tick` stays 0 while idle.
- R3: The resolution code sets the conversion length: 00 gives 6 bits and 8 core periods, 01 gives 8 bits and 10 periods, 10 gives 10 bits and 12 periods, 11 gives 12 bits and 14 periods. Exactly that many `core_tick` pulses occur per conversion.
- R4: `data_ready` is a one-cycle pulse that rises on the edge closing the final core period, which is LEN·N source cycles after the accepting edge (LEN core periods, N source cycles per core period). `busy` falls on that same edge.
- R5: With lead code E, `early_irq` is a one-cycle pulse that rises (E+1)·N source cycles before `data_ready`.
- R6: At 6-bit resolution, lead codes 100 to 111 are invalid and the lead is limited to 4 core periods. At 8-bit resolution, codes 110 and 111 are invalid and the lead is limited to 6. In both cases the conversion still completes.
- R7: `cfg_err` is updated on each accepted start: 1 for an invalid pair, 0 otherwise. It holds its value until the next accepted start.
- R8: The divider, resolution and lead inputs are sampled only on the accepting edge. Changing them during a conversion has no effect on its timing.
- R9: A `start` pulse while `busy` is ignored. A `start` in the cycle where `data_ready` is high is accepted.
- R10: `busy` rises on the edge at which `start` is sampled while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion start request |
| div_code | input | 7 | Core clock divider code |
| res_sel | input | 2 | Resolution code |
| lead_sel | input | 3 | Early-interrupt lead code |
| core_tick | output | 1 | Core clock enable, one source cycle per core period |
| busy | output | 1 | Conversion in progress |
| early_irq | output | 1 | Early interrupt pulse |
| data_ready | output | 1 | End-of-conversion pulse |
| cfg_err | output | 1 | Last accepted configuration was an invalid pair |

## Verification
Two events can share a single cycle:
- The final core tick, and a `start` that arrives while busy.
- The `data_ready` pulse, and a `start` for the next conversion.

The bench provokes the first by pulsing `start` in the middle of a conversion and at its close. It judges the result by the scoreboard timing of the running conversion, which must not move. It provokes the second by raising `start` right after `data_ready` rises. It expects a new conversion whose events are timed from that edge. Both events of the new conversion must be predicted exactly, and no stray pulse may appear in the scoreboard.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Sequencer control states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

    // Core periods added to the resolution to form the conversion length
    localparam int unsigned CONV_EXTRA = 2;
    // Conversion length at the lowest resolution code
    localparam int unsigned BASE_LEN   = 8;
    // Margin between the conversion length and the longest legal lead
    localparam int unsigned LEAD_GAP   = 4;

endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W  = 2,
    parameter int unsigned LEAD_W = 3,
    parameter int unsigned LEN_W  = 5
) (
    input  logic [RES_W-1:0]  res_code,
    input  logic [LEAD_W-1:0] lead_code,
    output logic [LEN_W-1:0]  conv_len,
    output logic [LEN_W-1:0]  lead_eff,
    output logic              pair_bad
);

    localparam logic [LEN_W-1:0] LEAD_CAP = LEN_W'(1 << LEAD_W);

    logic [LEN_W-1:0] lead_req;
    logic [LEN_W-1:0] lead_lim;

    always_comb begin
        // two core periods per resolution step
        conv_len = LEN_W'(BASE_LEN) + (LEN_W'(res_code) << 1);
        // longest lead that still fits into this conversion
        lead_lim = conv_len - LEN_W'(LEAD_GAP);
        if (lead_lim > LEAD_CAP) begin
            lead_lim = LEAD_CAP;
        end
        lead_req = LEN_W'(lead_code) + LEN_W'(1);
        pair_bad = (lead_req > lead_lim);
        lead_eff = pair_bad ? lead_lim : lead_req;
    end

endmodule

// File: rtl/seq_clk_div.sv
module seq_clk_div #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);

    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;
    logic [CNT_W-1:0] limit;

    always_comb begin
        // a zero code behaves like one
        half  = (code == '0) ? DIV_W'(1) : code;
        limit = {half, 1'b0} - CNT_W'(1);
        tick  = run && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/seq_conv_count.sv
module seq_conv_count #(
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic [LEN_W-1:0] lead_in,
    input  logic             tick,
    output logic             last,
    output logic             early
);

    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] lead_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            lead_q <= '0;
        end else if (load) begin
            rem_q  <= len_in;
            lead_q <= lead_in;
        end else if (tick && rem_q != '0) begin
            rem_q  <= rem_q - LEN_W'(1);
        end
    end

    always_comb begin
        last  = tick && (rem_q == LEN_W'(1));
        early = tick && (rem_q == lead_q + LEN_W'(1));
    end

endmodule

// File: rtl/adc_core_sequencer.sv
module adc_core_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned DIV_W  = 7,
    parameter int unsigned RES_W  = 2,
    parameter int unsigned LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_code,
    input  logic [RES_W-1:0]  res_sel,
    input  logic [LEAD_W-1:0] lead_sel,
    output logic              core_tick,
    output logic              busy,
    output logic              early_irq,
    output logic              data_ready,
    output logic              cfg_err
);

    localparam int unsigned LEN_W = RES_W + 3;

    seq_state_t       state_q;
    seq_state_t       state_nx;
    logic             accept;
    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_w;
    logic [LEN_W-1:0] lead_w;
    logic             bad_w;
    logic             conv_last;
    logic             conv_early;
    logic             tick_w;
    logic             busy_q;
    logic             early_q;
    logic             ready_q;
    logic             err_q;

    seq_cfg_check #(
        .RES_W (RES_W),
        .LEAD_W(LEAD_W),
        .LEN_W (LEN_W)
    ) i_cfg (
        .res_code (res_sel),
        .lead_code(lead_sel),
        .conv_len (len_w),
        .lead_eff (lead_w),
        .pair_bad (bad_w)
    );

    seq_clk_div #(
        .DIV_W(DIV_W)
    ) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(accept),
        .run  (state_q == ST_CONV),
        .code (div_q),
        .tick (tick_w)
    );

    seq_conv_count #(
        .LEN_W(LEN_W)
    ) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .len_in (len_w),
        .lead_in(lead_w),
        .tick   (tick_w),
        .last   (conv_last),
        .early  (conv_early)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_nx = ST_CONV;
            ST_CONV: if (conv_last) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // state register and sampled divider code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                div_q <= div_code;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            early_q <= 1'b0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            busy_q  <= (state_nx == ST_CONV);
            early_q <= conv_early;
            ready_q <= conv_last;
            if (accept) begin
                err_q <= bad_w;
            end
        end
    end

    assign core_tick  = tick_w;
    assign busy       = busy_q;
    assign early_irq  = early_q;
    assign data_ready = ready_q;
    assign cfg_err    = err_q;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic core_tick,
    input logic busy,
    input logic early_irq,
    input logic data_ready,
    input logic cfg_err
);

    // R2
    tick_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> busy);

    // R4
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> !data_ready);

    // R4
    ready_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> !busy);

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> data_ready);

    // R5
    early_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({early_irq, data_ready}));

    // R5
    early_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !core_tick |=> busy);

    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_err));

endmodule

bind adc_core_sequencer adc_seq_checker i_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .core_tick (core_tick),
    .busy      (busy),
    .early_irq (early_irq),
    .data_ready(data_ready),
    .cfg_err   (cfg_err)
);

// File: tb/test_adc_core_sequencer.sv
module test_adc_core_sequencer;

    logic       clk;
    logic       rst_n;
    logic       start;
    logic [6:0] div_code;
    logic [1:0] res_sel;
    logic [2:0] lead_sel;
    logic       core_tick;
    logic       busy;
    logic       early_irq;
    logic       data_ready;
    logic       cfg_err;

    typedef struct {
        int kind;   // 0 early, 1 ready
        int cyc;
        int err;
        int len;
    } exp_t;

    exp_t exp_q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    int   ticks = 0;
    bit   done  = 0;

    adc_core_sequencer i_adc_core_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .div_code  (div_code),
        .res_sel   (res_sel),
        .lead_sel  (lead_sel),
        .core_tick (core_tick),
        .busy      (busy),
        .early_irq (early_irq),
        .data_ready(data_ready),
        .cfg_err   (cfg_err)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (core_tick) ticks++;
            if (early_irq || data_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected pulse", int'(data_ready), 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (early_irq) begin
                        check(it.kind == 0, "R5 early pulse order", 0, it.kind);
                        check(it.cyc == cyc, "R5 early timing", cyc, it.cyc);
                    end else begin
                        check(it.kind == 1, "R4 ready pulse order", 1, it.kind);
                        check(it.cyc == cyc, "R4 ready timing", cyc, it.cyc);
                        check(ticks == it.len, "R3 core tick count", ticks, it.len);
                        check(busy == 1'b0, "R4 busy low with ready", int'(busy), 0);
                        check(int'(cfg_err) == it.err, "R7 cfg_err value", int'(cfg_err), it.err);
                        ticks = 0;
                    end
                end
            end
        end
    end

    // driver: pulses start and pushes predicted events
    task automatic launch(input int dv, input int rs, input int ld, input bit disturb);
        int n, len, lmax, l, e, s;
        div_code = 7'(dv);
        res_sel  = 2'(rs);
        lead_sel = 3'(ld);
        start    = 1;
        @(posedge clk);
        #1;
        s     = cyc;
        start = 0;
        // R10
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        n    = 2 * ((dv == 0) ? 1 : dv);
        len  = 8 + 2 * rs;
        lmax = len - 4;
        if (lmax > 8) lmax = 8;
        l = ld + 1;
        e = 0;
        // R6 clamp
        if (l > lmax) begin
            l = lmax;
            e = 1;
        end
        exp_q.push_back('{0, s + (len - l) * n, 0, 0});
        exp_q.push_back('{1, s + len * n, e, len});
        if (disturb) begin
            // R8 inputs change during conversion
            div_code = ~div_code;
            res_sel  = ~res_sel;
            lead_sel = ~lead_sel;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int dv, input int rs, input int ld, input bit disturb);
        @(negedge clk);
        launch(dv, rs, ld, disturb);
        if (disturb) begin
            repeat (5) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
            // R9 start while busy ignored
            check(busy == 1'b1, "R9 busy kept after ignored start", int'(busy), 1);
        end
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", cyc, 150000);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        rst_n    = 0;
        start    = 0;
        div_code = 0;
        res_sel  = 0;
        lead_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", int'(busy), 0);
        check(core_tick == 0, "R1 core_tick", int'(core_tick), 0);
        check(early_irq == 0, "R1 early_irq", int'(early_irq), 0);
        check(data_ready == 0, "R1 data_ready", int'(data_ready), 0);
        check(cfg_err == 0, "R1 cfg_err", int'(cfg_err), 0);
        rst_n = 1;

        // R2 zero code acts like one, R3 6-bit length
        run(0, 0, 0, 0);
        run(1, 0, 0, 0);
        // R3 12-bit with longest lead
        run(3, 3, 7, 0);
        // R6 invalid 8-bit pair, R7 flag set
        run(2, 1, 7, 0);
        // R6 invalid 6-bit pair
        run(1, 0, 4, 0);
        // R7 valid pair clears flag, R8 and R9 disturbance
        run(2, 2, 5, 1);
        // R6 last valid 8-bit code
        run(1, 1, 5, 0);
        // R2 largest divider
        run(127, 0, 0, 0);

        // R2 no core tick while idle
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(core_tick == 0, "R2 idle core_tick", int'(core_tick), 0);
        end

        // R9 start coinciding with the final tick is ignored,
        // start in the data_ready cycle is accepted
        @(negedge clk);
        launch(1, 0, 1, 0);
        while (!(core_tick && exp_q.size() == 1 && exp_q[0].cyc == cyc + 1)) @(negedge clk);
        start = 1;
        @(posedge data_ready);
        #1;
        launch(2, 1, 2, 0);
        check(exp_q.size() == 2, "R9 back-to-back queued", exp_q.size(), 2);
        drain();

        check(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule